// File: doc/BRIEF.md
# Pipelined Decision-Tree Flow Lookup Engine

This block classifies packet header keys by walking a decision tree whose depth has a fixed upper bound. Every tree level lives in a node memory of its own, and one pipeline stage reads each memory. An internal node names a header field, a bit offset inside that field and a power-of-two number of cuts. The key bits picked by those values are added to the node's child base address, and the sum addresses the next level. A leaf either ends the search as a miss or points to a short list of candidate rules in a rule table. A final stage checks those candidates in full against the key.

Each node memory has two read ports and so does the rule table. Two independent lanes therefore accept one key each on every clock. A key that resolves at a shallow leaf rides the remaining stages with its result frozen. Every result leaves after a fixed latency of one cycle per level plus one cycle for the rule check. Node and rule contents come from simple write ports, and the tree builder outside the block drives them.

Top module: `dtw_engine`

## Requirements
- R1: While reset is asserted, and for the first LEVELS+1 cycles after it is released, `out_vld` is 0 in both lanes. A reset applied while lookups are in flight discards them.
- R2: A key accepted with `in_vld[l]=1` gives exactly one result on lane l, with `out_vld[l]=1`, exactly LEVELS+1 clock edges later. No result appears in any other cycle, and `out_hit` is never 1 without `out_vld`.
- R3: The search starts at address 0 of level 0. A node word is, from MSB down: leaf, hit, field select (2 bits), bit offset (3), cut bits (2), child base (NODE_AW), rule pointer (RULE_AW). An internal node (leaf=0) sends the key to the next level at address base + key[fsel*FIELD_W+offset +: cutbits], wrapping modulo 2^NODE_AW.
- R4: An internal node with cut bits 0 has exactly one child, at its base address, whatever the key.
- R5: A key that meets a leaf above the last level carries that leaf's hit flag and rule pointer unchanged through the deeper levels. The contents of the deeper levels have no effect on it.
- R6: A leaf with hit=0 gives a miss: `out_hit=0` and `out_rule=0`, whatever the rule table holds.
- R7: A key that is still at an internal node in the last level gives a miss.
- R8: A rule word is {valid, value[KEY_W], mask[KEY_W]}. For a hit leaf with pointer p, entries p..p+LIST_LEN-1 (modulo the table size) are tried in that order. The first entry with valid=1 and ((key ^ value) & mask) = 0 is reported as `out_hit=1` with `out_rule` set to its index. If no entry qualifies, the result is a miss with `out_rule=0`.
- R9: The two lanes are independent. Different keys entered in the same cycle each get their own result, and an idle lane produces none.
- R10: A node or rule write is seen by every lookup that reads that word in a later cycle. Rewriting a word between lookups changes the result accordingly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| node_we | input | 1 | Node memory write strobe |
| node_lvl | input | LVL_W | Level whose memory is written |
| node_addr | input | NODE_AW | Node address to write |
| node_wdata | input | NODE_W | Node word |
| rule_we | input | 1 | Rule table write strobe |
| rule_addr | input | RULE_AW | Rule index to write |
| rule_wdata | input | 2*KEY_W+1 | Rule word {valid, value, mask} |
| in_vld | input | 2 | Key valid, one bit per lane |
| in_key | input | 2 x KEY_W | Header key per lane |
| out_vld | output | 2 | Result valid per lane |
| out_hit | output | 2 | A rule matched |
| out_rule | output | 2 x RULE_AW | Index of the matched rule, 0 on a miss |

## Verification
The bench builds a three-level tree with one shallow leaf, a null leaf, a single-child cut and an internal node in the last level. Under the shallow leaf, the deeper levels hold a decoy leaf that would hit a catch-all rule, so a design that keeps walking after a leaf returns the wrong rule index. The candidate lists include an invalid entry that would otherwise match, a list that wraps past the top of the table, and a list with no match. These catch priority errors, missing valid gating and wrong wrap-around with visible wrong indices. A mid-flight reset, a single-lane latency count and a rewrite of the null leaf show stray results, an off-by-one latency and stale memory reads.

// File: rtl/dtw_pkg.sv
package dtw_pkg;
  // Bits of a key picked for a cut: nb bits starting at bit offset off.
  function automatic logic [63:0] cut_field(logic [63:0] key, int unsigned off,
                                            int unsigned nb);
    logic [63:0] m;
    m = (64'd1 << nb) - 64'd1;
    return (key >> off) & m;
  endfunction

  // Ternary compare: every bit set in m must agree between a and b.
  function automatic logic masked_eq(logic [63:0] a, logic [63:0] b, logic [63:0] m);
    return ((a ^ b) & m) == 64'd0;
  endfunction
endpackage

// File: rtl/dtw_level.sv
module dtw_level #(
  parameter int KEY_W   = 32,
  parameter int FIELD_W = 8,
  parameter int FSEL_W  = 2,
  parameter int POS_W   = 3,
  parameter int CB_W    = 2,
  parameter int NODE_AW = 4,
  parameter int RULE_AW = 5,
  parameter bit LAST    = 1'b0,
  localparam int NW = 2 + FSEL_W + POS_W + CB_W + NODE_AW + RULE_AW
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [NODE_AW-1:0]            waddr,
  input  logic [NW-1:0]                 wdata,
  input  logic [1:0]                    i_vld,
  input  logic [1:0]                    i_done,
  input  logic [1:0]                    i_hit,
  input  logic [1:0][KEY_W-1:0]         i_key,
  input  logic [1:0][NODE_AW-1:0]       i_addr,
  input  logic [1:0][RULE_AW-1:0]       i_rptr,
  output logic [1:0]                    o_vld,
  output logic [1:0]                    o_done,
  output logic [1:0]                    o_hit,
  output logic [1:0][KEY_W-1:0]         o_key,
  output logic [1:0][NODE_AW-1:0]       o_addr,
  output logic [1:0][RULE_AW-1:0]       o_rptr
);
  localparam int DEPTH    = 1 << NODE_AW;
  localparam int BASE_LSB = RULE_AW;
  localparam int NB_LSB   = BASE_LSB + NODE_AW;
  localparam int POS_LSB  = NB_LSB + CB_W;
  localparam int FSEL_LSB = POS_LSB + POS_W;
  localparam int HIT_BIT  = FSEL_LSB + FSEL_W;
  localparam int LEAF_BIT = HIT_BIT + 1;

  logic [NW-1:0]               mem [DEPTH];
  logic [1:0][NW-1:0]          node;
  logic [1:0]                  n_done, n_hit;
  logic [1:0][NODE_AW-1:0]     n_addr;
  logic [1:0][RULE_AW-1:0]     n_rptr;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Two read ports, one per lane.
  always_comb begin
    for (int l = 0; l < 2; l++) begin
      node[l]   = mem[i_addr[l]];
      n_done[l] = i_done[l];
      n_hit[l]  = i_hit[l];
      n_rptr[l] = i_rptr[l];
      n_addr[l] = i_addr[l];
      if (!i_done[l]) begin
        if (node[l][LEAF_BIT]) begin
          n_done[l] = 1'b1;
          n_hit[l]  = node[l][HIT_BIT];
          n_rptr[l] = node[l][RULE_AW-1:0];
        end else if (LAST) begin
          n_done[l] = 1'b1;
          n_hit[l]  = 1'b0;
          n_rptr[l] = '0;
        end else begin
          n_addr[l] = node[l][BASE_LSB +: NODE_AW] + NODE_AW'(dtw_pkg::cut_field(
                        64'(i_key[l]),
                        FIELD_W * 32'(node[l][FSEL_LSB +: FSEL_W]) + 32'(node[l][POS_LSB +: POS_W]),
                        32'(node[l][NB_LSB +: CB_W])));
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_vld  <= '0;
      o_done <= '0;
      o_hit  <= '0;
      o_key  <= '0;
      o_addr <= '0;
      o_rptr <= '0;
    end else begin
      o_vld  <= i_vld;
      o_done <= n_done;
      o_hit  <= n_hit;
      o_key  <= i_key;
      o_addr <= n_addr;
      o_rptr <= n_rptr;
    end
  end
endmodule

// File: rtl/dtw_leaf_match.sv
module dtw_leaf_match #(
  parameter int KEY_W    = 32,
  parameter int RULE_AW  = 5,
  parameter int LIST_LEN = 4,
  localparam int RW = 2 * KEY_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [RULE_AW-1:0]       waddr,
  input  logic [RW-1:0]            wdata,
  input  logic [1:0]               i_vld,
  input  logic [1:0]               i_hit,
  input  logic [1:0][KEY_W-1:0]    i_key,
  input  logic [1:0][RULE_AW-1:0]  i_rptr,
  output logic [1:0]               o_vld,
  output logic [1:0]               o_hit,
  output logic [1:0][RULE_AW-1:0]  o_rule
);
  localparam int DEPTH = 1 << RULE_AW;

  logic [RW-1:0]              rmem [DEPTH];
  logic [1:0]                 found;
  logic [1:0][RULE_AW-1:0]    pick;

  always_ff @(posedge clk) begin
    if (we) rmem[waddr] <= wdata;
  end

  // Walk the list from its tail so the earliest match wins.
  always_comb begin
    logic [RULE_AW-1:0] idx;
    logic [RW-1:0]      ent;
    for (int l = 0; l < 2; l++) begin
      found[l] = 1'b0;
      pick[l]  = '0;
      for (int j = LIST_LEN - 1; j >= 0; j--) begin
        idx = i_rptr[l] + RULE_AW'(j);
        ent = rmem[idx];
        if (ent[RW-1] && dtw_pkg::masked_eq(64'(i_key[l]), 64'(ent[KEY_W +: KEY_W]),
                                            64'(ent[KEY_W-1:0]))) begin
          found[l] = 1'b1;
          pick[l]  = idx;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_vld  <= '0;
      o_hit  <= '0;
      o_rule <= '0;
    end else begin
      o_vld <= i_vld;
      for (int l = 0; l < 2; l++) begin
        o_hit[l]  <= i_vld[l] & i_hit[l] & found[l];
        o_rule[l] <= (i_vld[l] & i_hit[l] & found[l]) ? pick[l] : '0;
      end
    end
  end
endmodule

// File: rtl/dtw_engine.sv
module dtw_engine #(
  parameter int FIELDS   = 4,
  parameter int FIELD_W  = 8,
  parameter int LEVELS   = 3,
  parameter int NODE_AW  = 4,
  parameter int RULE_AW  = 5,
  parameter int LIST_LEN = 4,
  parameter int CB_W     = 2,
  localparam int KEY_W   = FIELDS * FIELD_W,
  localparam int FSEL_W  = (FIELDS > 1) ? $clog2(FIELDS) : 1,
  localparam int POS_W   = (FIELD_W > 1) ? $clog2(FIELD_W) : 1,
  localparam int NODE_W  = 2 + FSEL_W + POS_W + CB_W + NODE_AW + RULE_AW,
  localparam int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     node_we,
  input  logic [LVL_W-1:0]         node_lvl,
  input  logic [NODE_AW-1:0]       node_addr,
  input  logic [NODE_W-1:0]        node_wdata,
  input  logic                     rule_we,
  input  logic [RULE_AW-1:0]       rule_addr,
  input  logic [2*KEY_W:0]         rule_wdata,
  input  logic [1:0]               in_vld,
  input  logic [1:0][KEY_W-1:0]    in_key,
  output logic [1:0]               out_vld,
  output logic [1:0]               out_hit,
  output logic [1:0][RULE_AW-1:0]  out_rule
);
  // Stage boundaries: index 0 is the block input, index LEVELS feeds the rule check.
  logic [1:0]                 st_vld  [LEVELS+1];
  logic [1:0]                 st_done [LEVELS+1];
  logic [1:0]                 st_hit  [LEVELS+1];
  logic [1:0][KEY_W-1:0]      st_key  [LEVELS+1];
  logic [1:0][NODE_AW-1:0]    st_addr [LEVELS+1];
  logic [1:0][RULE_AW-1:0]    st_rptr [LEVELS+1];

  assign st_vld[0]  = in_vld;
  assign st_done[0] = '0;
  assign st_hit[0]  = '0;
  assign st_key[0]  = in_key;
  assign st_addr[0] = '0;
  assign st_rptr[0] = '0;

  for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
    dtw_level #(
      .KEY_W(KEY_W), .FIELD_W(FIELD_W), .FSEL_W(FSEL_W), .POS_W(POS_W),
      .CB_W(CB_W), .NODE_AW(NODE_AW), .RULE_AW(RULE_AW), .LAST(k == LEVELS - 1)
    ) u_lvl (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (node_we && (node_lvl == LVL_W'(k))),
      .waddr  (node_addr),
      .wdata  (node_wdata),
      .i_vld  (st_vld[k]),
      .i_done (st_done[k]),
      .i_hit  (st_hit[k]),
      .i_key  (st_key[k]),
      .i_addr (st_addr[k]),
      .i_rptr (st_rptr[k]),
      .o_vld  (st_vld[k+1]),
      .o_done (st_done[k+1]),
      .o_hit  (st_hit[k+1]),
      .o_key  (st_key[k+1]),
      .o_addr (st_addr[k+1]),
      .o_rptr (st_rptr[k+1])
    );
  end

  dtw_leaf_match #(.KEY_W(KEY_W), .RULE_AW(RULE_AW), .LIST_LEN(LIST_LEN)) u_match (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (rule_we),
    .waddr  (rule_addr),
    .wdata  (rule_wdata),
    .i_vld  (st_vld[LEVELS]),
    .i_hit  (st_hit[LEVELS]),
    .i_key  (st_key[LEVELS]),
    .i_rptr (st_rptr[LEVELS]),
    .o_vld  (out_vld),
    .o_hit  (out_hit),
    .o_rule (out_rule)
  );
endmodule

// File: rtl/dtw_engine_chk.sv
module dtw_engine_chk #(
  parameter int LEVELS   = 3,
  parameter int RULE_AW  = 5,
  parameter int LIST_LEN = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [1:0]               in_vld,
  input logic [1:0]               out_vld,
  input logic [1:0]               out_hit,
  input logic [1:0][RULE_AW-1:0]  out_rule,
  input logic [1:0]               st_vld  [LEVELS+1],
  input logic [1:0]               st_done [LEVELS+1],
  input logic [1:0]               st_hit  [LEVELS+1],
  input logic [1:0][RULE_AW-1:0]  st_rptr [LEVELS+1]
);
  localparam int LAT = LEVELS + 1;

  // Independent delay line of accepted keys, used instead of a deep $past.
  logic [1:0] vdly [LAT];
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) vdly[i] <= '0;
    end else begin
      vdly[0] <= in_vld;
      for (int i = 1; i < LAT; i++) vdly[i] <= vdly[i-1];
    end
  end

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> out_vld == 2'b00); // R1

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld == vdly[LAT-1]); // R2

  for (genvar l = 0; l < 2; l++) begin : g_lane
    AST_HIT_HAS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_hit[l] |-> out_vld[l]); // R2

    AST_MISS_ZERO_RULE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld[l] && !out_hit[l]) |-> out_rule[l] == '0); // R6

    AST_NULL_LEAF_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      (st_vld[LEVELS][l] && !st_hit[LEVELS][l]) |=> !out_hit[l]); // R6

    AST_TREE_RESOLVED: assert property (@(posedge clk) disable iff (!rst_n)
      st_vld[LEVELS][l] |-> st_done[LEVELS][l]); // R7

    AST_HIT_IN_LIST: assert property (@(posedge clk) disable iff (!rst_n)
      (st_vld[LEVELS][l] && st_hit[LEVELS][l]) |=>
        (!out_hit[l] || (32'(RULE_AW'(out_rule[l] - $past(st_rptr[LEVELS][l]))) < LIST_LEN))); // R8

    for (genvar k = 2; k <= LEVELS; k++) begin : g_keep
      AST_LEAF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_vld[k-1][l] && st_done[k-1][l]) |=>
          (st_done[k][l] && st_hit[k][l] == $past(st_hit[k-1][l]) &&
           st_rptr[k][l] == $past(st_rptr[k-1][l]))); // R5
    end
  end
endmodule

bind dtw_engine dtw_engine_chk #(.LEVELS(LEVELS), .RULE_AW(RULE_AW), .LIST_LEN(LIST_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .out_vld(out_vld), .out_hit(out_hit),
  .out_rule(out_rule), .st_vld(st_vld), .st_done(st_done), .st_hit(st_hit), .st_rptr(st_rptr)
);

// File: tb/dtw_engine_test.sv
module dtw_engine_test;
  localparam int KEY_W = 32;
  localparam int RAW   = 5;
  localparam int LEVELS = 3;
  localparam int LAT   = LEVELS + 1;
  localparam int NVEC  = 12;
  localparam int NPAIR = NVEC / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic node_we = 1'b0;
  logic [1:0] node_lvl = '0;
  logic [3:0] node_addr = '0;
  logic [17:0] node_wdata = '0;
  logic rule_we = 1'b0;
  logic [RAW-1:0] rule_addr = '0;
  logic [2*KEY_W:0] rule_wdata = '0;
  logic [1:0] in_vld = '0;
  logic [1:0][KEY_W-1:0] in_key = '0;
  logic [1:0] out_vld, out_hit;
  logic [1:0][RAW-1:0] out_rule;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dtw_engine uut (
    .clk(clk), .rst_n(rst_n), .node_we(node_we), .node_lvl(node_lvl),
    .node_addr(node_addr), .node_wdata(node_wdata), .rule_we(rule_we),
    .rule_addr(rule_addr), .rule_wdata(rule_wdata), .in_vld(in_vld),
    .in_key(in_key), .out_vld(out_vld), .out_hit(out_hit), .out_rule(out_rule)
  );

  // {key, expected hit, expected rule index}; even rows lane 0, odd rows lane 1.
  localparam logic [KEY_W+RAW:0] VEC [NVEC] = '{
    {32'h0000_1100, 1'b1, 5'd0},   // R5 shallow leaf, first entry
    {32'h0000_2200, 1'b1, 5'd1},   // R8 falls to catch-all
    {32'h4000_00AA, 1'b1, 5'd8},   // R3 two-level cut
    {32'h4000_0B00, 1'b1, 5'd10},  // R8 skips invalid entry
    {32'h4000_0C00, 1'b0, 5'd0},   // R8 empty list result
    {32'h4000_0001, 1'b0, 5'd0},   // R7 internal at last level
    {32'h8000_1100, 1'b0, 5'd0},   // R6 null leaf
    {32'hC000_0055, 1'b1, 5'd31},  // R4 single child
    {32'hC000_1100, 1'b1, 5'd0},   // R8 list wraps
    {32'hC000_0000, 1'b1, 5'd1},   // R8 wrap to catch-all
    {32'hFF00_1155, 1'b1, 5'd31},  // R8 order beats later match
    {32'h3F00_1100, 1'b1, 5'd0}    // R3 only top two bits steer
  };

  function automatic logic [17:0] mk_node(bit leaf, bit hit, int fsel, int pos, int nb,
                                          int base, int rptr);
    return {leaf, hit, 2'(fsel), 3'(pos), 2'(nb), 4'(base), 5'(rptr)};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_node(int lvl, int addr, logic [17:0] w);
    node_lvl = 2'(lvl); node_addr = 4'(addr); node_wdata = w; node_we = 1'b1;
    @(negedge clk);
    node_we = 1'b0;
  endtask

  task automatic wr_rule(int addr, bit v, logic [31:0] val, logic [31:0] msk);
    rule_addr = 5'(addr); rule_wdata = {v, val, msk}; rule_we = 1'b1;
    @(negedge clk);
    rule_we = 1'b0;
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check(out_vld == 2'b00, "R1 during reset", int'(out_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_vld == 2'b00, "R1 after reset", int'(out_vld), 0);

    // Tree: level 0 cuts key[31:30]; level 1 holds a shallow leaf, a one-bit cut,
    // a null leaf and a single-child node; level 2 holds a decoy under the shallow leaf.
    wr_node(0, 0,  mk_node(0, 0, 3, 6, 2, 0, 0));
    wr_node(1, 0,  mk_node(1, 1, 0, 0, 0, 0, 0));
    wr_node(1, 1,  mk_node(0, 0, 0, 0, 1, 4, 0));
    wr_node(1, 2,  mk_node(1, 0, 0, 0, 0, 0, 0));
    wr_node(1, 3,  mk_node(0, 0, 0, 0, 0, 14, 0));
    wr_node(2, 0,  mk_node(1, 1, 0, 0, 0, 0, 20));
    wr_node(2, 4,  mk_node(1, 1, 0, 0, 0, 0, 8));
    wr_node(2, 5,  mk_node(0, 0, 0, 0, 0, 0, 0));
    wr_node(2, 14, mk_node(1, 1, 0, 0, 0, 0, 30));
    wr_rule(0,  1'b1, 32'h0000_1100, 32'h0000_FF00);
    wr_rule(1,  1'b1, 32'h0,         32'h0);
    wr_rule(8,  1'b1, 32'h0000_00AA, 32'h0000_00FF);
    wr_rule(9,  1'b0, 32'h0,         32'h0);
    wr_rule(10, 1'b1, 32'h0000_0B00, 32'h0000_FF00);
    wr_rule(11, 1'b0, 32'h0,         32'h0);
    wr_rule(20, 1'b1, 32'h0,         32'h0);
    wr_rule(30, 1'b0, 32'h0,         32'h0);
    wr_rule(31, 1'b1, 32'h0000_0055, 32'h0000_00FF);
    check(out_vld == 2'b00, "R1 idle after writes", int'(out_vld), 0);

    // Stream two keys per cycle (R9) and compare each result LAT cycles later (R2).
    for (int c = 0; c < NPAIR + LAT; c++) begin
      if (c >= LAT) begin
        for (int l = 0; l < 2; l++) begin
          int v;
          v = 2 * (c - LAT) + l;
          check(out_vld[l] == 1'b1, "R2 result valid", int'(out_vld[l]), 1);
          check(out_hit[l] == VEC[v][RAW], "R3-R8 hit flag (vector row)", int'(out_hit[l]),
                int'(VEC[v][RAW]));
          check(out_rule[l] == VEC[v][RAW-1:0], "R8 rule index (R3 R4 R5 R6 R7)",
                int'(out_rule[l]), int'(VEC[v][RAW-1:0]));
        end
      end else begin
        check(out_vld == 2'b00, "R2 no early result", int'(out_vld), 0);
      end
      if (c < NPAIR) begin
        in_vld = 2'b11;
        in_key[0] = VEC[2*c][KEY_W+RAW:RAW+1];
        in_key[1] = VEC[2*c+1][KEY_W+RAW:RAW+1];
      end else begin
        in_vld = 2'b00;
      end
      @(negedge clk);
    end
    check(out_vld == 2'b00, "R2 no extra result", int'(out_vld), 0);

    // R2/R9: single key on lane 0 only, count edges to its result.
    in_vld = 2'b01; in_key[0] = 32'h0000_2200; in_key[1] = 32'h8000_1100;
    @(negedge clk);
    in_vld = 2'b00;
    n = 1;
    while (!out_vld[0] && n < 10) begin
      check(out_vld[1] == 1'b0, "R9 idle lane silent", int'(out_vld[1]), 0);
      @(negedge clk);
      n++;
    end
    check(n == LAT, "R2 latency in cycles", n, LAT);
    check(out_vld[1] == 1'b0, "R9 idle lane silent at result", int'(out_vld[1]), 0);
    check(out_hit[0] && out_rule[0] == 5'd1, "R2 single-lane rule", int'(out_rule[0]), 1);
    @(negedge clk);

    // R10: turn the null leaf into a hit leaf pointing at list 8.
    wr_node(1, 2, mk_node(1, 1, 0, 0, 0, 0, 8));
    in_vld = 2'b10; in_key[1] = 32'h8000_00AA;
    @(negedge clk);
    in_vld = 2'b00;
    repeat (LAT - 1) @(negedge clk);
    check(out_vld[1] && out_hit[1], "R10 rewritten leaf hits", int'(out_hit[1]), 1);
    check(out_rule[1] == 5'd8, "R10 rewritten leaf rule", int'(out_rule[1]), 8);
    @(negedge clk);

    // R1: reset while lookups are in flight discards them.
    in_vld = 2'b11; in_key[0] = 32'h0000_1100; in_key[1] = 32'hC000_0055;
    @(negedge clk);
    in_vld = 2'b00;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < LAT + 1; i++) begin
      check(out_vld == 2'b00, "R1 in-flight dropped", int'(out_vld), 0);
      @(negedge clk);
    end

    finish_run();
  end
endmodule